// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This block works out where an 8-bit processor's instruction finds its operand. It is started once per instruction with an addressing-mode code, the program counter just past the opcode, both index registers and two qualifiers: whether the instruction is a store, and whether a branch is taken. It then fetches the operand bytes, and any pointer bytes, over a byte-wide read port. When it finishes it reports four things: the effective address, the program counter advanced past the operand, the raw relative offset, and how many extra cycles the instruction owes for page crossings.

The controller is a six-state machine. `S_IDLE` waits for `start`. Modes that need no bus traffic (accumulator, implied, immediate, and the unused codes) complete combinationally in the start cycle and never leave `S_IDLE`. Every other mode takes the transition `S_IDLE -> S_OPLO`, which reads the first operand byte. From `S_OPLO` the machine takes one of three transitions: to `S_OPHI` for two-byte operands, to `S_PTLO` for the zero-page pointer modes, or to `S_FIN` for one-byte operands. From `S_OPHI` it goes to `S_PTLO` for the indirect mode and to `S_FIN` otherwise. After that it always runs `S_PTLO -> S_PTHI -> S_FIN -> S_IDLE`. `done` is high for the one cycle spent in `S_FIN`, or for the start cycle on the fast path.

The read port is combinational: `rd_data` must reflect `rd_addr` within the same cycle that `rd_en` is high.

Top module: `eff_addr_gen`

## Requirements
- R1: During and right after reset `done`, `rd_en` and `busy` are low.
- R2: Mode codes 0 (accumulator) and 1 (implied) raise `done` in the start cycle with no read, `ea`=0, `pc_out`=`pc_in`, `extra`=0 and `rel_off`=0.
- R3: Mode code 2 (immediate) raises `done` in the start cycle with no read, `ea`=`pc_in` and `pc_out`=`pc_in`+1.
- R4: Mode codes 3, 4 and 5 (zero page, plain, +X, +Y) read one byte at the PC. `ea` is {0x00, (byte+index) mod 256}, `pc_out`=PC+1 and `extra`=0.
- R5: Mode code 6 (absolute) reads the low byte at PC and then the high byte at PC+1. `ea`={high,low} and `pc_out`=PC+2.
- R6: Mode codes 7 and 8 (absolute +X, +Y) give `ea`={high,low}+index (16-bit wrap). `extra`=1 when the store qualifier is set or when `ea`[15:8] differs from the high byte, and 0 otherwise.
- R7: Mode code 10 (pre-indexed) sets z=(byte+X) mod 256, reads the pointer low byte at z and the high byte at (z+1) mod 256, both in page 0. `ea` is the pointer and `pc_out`=PC+1.
- R8: Mode code 11 (post-indexed) reads the pointer at byte and at (byte+1) mod 256 in page 0. `ea`=pointer+Y, and `extra` follows the rule of R6 with the pointer as base.
- R9: Mode code 9 (indirect) reads the pointer low byte at {high,low} and the high byte at {high,(low+1) mod 256}, so the page never carries. `pc_out`=PC+2.
- R10: Mode code 12 (relative) reads one offset byte into `rel_off`. It sets `pc_out`=PC+1 and `ea`=`pc_out`+sign-extended offset. `extra` is 0 when the branch is not taken, 1 when it is taken within the same page, and 2 when the taken target's page differs from `pc_out`'s page. `extra` never reads 3.
- R11: Counting the start cycle as 0, `done` comes in cycle 2 for zero-page and relative modes, cycle 3 for absolute modes, cycle 4 for pre- and post-indexed modes and cycle 5 for indirect. The number of cycles with `rd_en` high is 1, 2, 3 and 4 respectively.
- R12: While `busy` is high, `start` and all command inputs are ignored; the result reflects the values captured at start.
- R13: Mode codes 13 to 15 behave as implied (R2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one address computation |
| mode | input | 4 | Addressing-mode code |
| idx_x | input | DW | X index register |
| idx_y | input | DW | Y index register |
| pc_in | input | 2*DW | PC pointing at the first operand byte |
| is_store | input | 1 | Instruction is a store (forces indexed penalty) |
| br_taken | input | 1 | Branch condition is true (relative mode) |
| rd_en | output | 1 | Read strobe |
| rd_addr | output | 2*DW | Read address |
| rd_data | input | DW | Read data, same cycle as `rd_addr` |
| done | output | 1 | Result valid this cycle |
| busy | output | 1 | Sequence in progress |
| ea | output | 2*DW | Effective address or branch target |
| pc_out | output | 2*DW | PC after the operand bytes |
| rel_off | output | DW | Raw relative offset byte |
| extra | output | 2 | Extra cycles owed |

## Verification
The bench uses the default DW=8, which gives a 16-bit address space. It can then supply memory as a fixed arithmetic function of the address instead of a stored array. Sweeping all sixteen mode codes against many PC, index, store and taken combinations produces page crossings, zero-page pointer wraps at 0xFF, and branch targets on both sides of a page edge. A directed run places the indirect pointer's low byte at 0xFF to expose the no-carry rule. Some runs also drive a conflicting command in every busy cycle.

// File: rtl/eag_pkg.sv
package eag_pkg;

    typedef enum logic [3:0] {
        AM_ACC = 4'd0,
        AM_IMP = 4'd1,
        AM_IMM = 4'd2,
        AM_ZPG = 4'd3,
        AM_ZPX = 4'd4,
        AM_ZPY = 4'd5,
        AM_ABS = 4'd6,
        AM_ABX = 4'd7,
        AM_ABY = 4'd8,
        AM_IND = 4'd9,
        AM_IDX = 4'd10,
        AM_IDY = 4'd11,
        AM_REL = 4'd12
    } amode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OPLO,
        S_OPHI,
        S_PTLO,
        S_PTHI,
        S_FIN
    } eag_state_e;

    // Modes completed in the start cycle without bus traffic
    function automatic logic is_fast(input logic [3:0] m);
        return (m <= 4'd2) || (m > 4'd12);
    endfunction

endpackage

// File: rtl/eag_page_cross.sv
module eag_page_cross #(
    parameter int DW = 8
) (
    input  logic [2*DW-1:0] base,
    input  logic [2*DW-1:0] dest,
    output logic            crossed
);
    always_comb begin
        crossed = (base[2*DW-1:DW] != dest[2*DW-1:DW]);
    end
endmodule

// File: rtl/eag_addr_calc.sv
module eag_addr_calc
    import eag_pkg::*;
#(
    parameter int DW = 8
) (
    input  amode_e           mode_q,
    input  logic [DW-1:0]    op0,
    input  logic [DW-1:0]    op1,
    input  logic [DW-1:0]    plo,
    input  logic [DW-1:0]    phi,
    input  logic [DW-1:0]    x_q,
    input  logic [DW-1:0]    y_q,
    input  logic [2*DW-1:0]  pc_q,
    input  logic             store_q,
    input  logic             taken_q,
    output logic [2*DW-1:0]  ea,
    output logic [DW-1:0]    rel,
    output logic [1:0]       extra
);
    localparam int AW = 2 * DW;

    logic [AW-1:0] idx_base;
    logic [DW-1:0] idx_val;
    logic [AW-1:0] idx_sum;
    logic [AW-1:0] br_target;
    logic          idx_cross;
    logic          br_cross;

    always_comb begin
        idx_base = (mode_q == AM_IDY) ? {phi, plo} : {op1, op0};
        idx_val  = (mode_q == AM_ABX) ? x_q : y_q;
        idx_sum  = idx_base + {{DW{1'b0}}, idx_val};
        br_target = pc_q + {{DW{op0[DW-1]}}, op0};
    end

    eag_page_cross #(.DW(DW)) u_idx_cross (
        .base   (idx_base),
        .dest   (idx_sum),
        .crossed(idx_cross)
    );

    eag_page_cross #(.DW(DW)) u_br_cross (
        .base   (pc_q),
        .dest   (br_target),
        .crossed(br_cross)
    );

    always_comb begin
        ea    = '0;
        rel   = '0;
        extra = 2'd0;
        unique case (mode_q)
            AM_ZPG: ea = {{DW{1'b0}}, op0};
            AM_ZPX: ea = {{DW{1'b0}}, DW'(op0 + x_q)};
            AM_ZPY: ea = {{DW{1'b0}}, DW'(op0 + y_q)};
            AM_ABS: ea = {op1, op0};
            AM_ABX, AM_ABY, AM_IDY: begin
                ea    = idx_sum;
                extra = (store_q || idx_cross) ? 2'd1 : 2'd0;
            end
            AM_IND, AM_IDX: ea = {phi, plo};
            AM_REL: begin
                ea    = br_target;
                rel   = op0;
                extra = taken_q ? (br_cross ? 2'd2 : 2'd1) : 2'd0;
            end
            default: ea = '0;
        endcase
    end
endmodule

// File: rtl/eag_fsm.sv
module eag_fsm
    import eag_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [3:0]       mode,
    input  logic [DW-1:0]    idx_x,
    input  logic [DW-1:0]    idx_y,
    input  logic [2*DW-1:0]  pc_in,
    input  logic             is_store,
    input  logic             br_taken,
    input  logic [DW-1:0]    rd_data,
    output logic             rd_en,
    output logic [2*DW-1:0]  rd_addr,
    output eag_state_e       state_o,
    output amode_e           mode_q,
    output logic [DW-1:0]    op0,
    output logic [DW-1:0]    op1,
    output logic [DW-1:0]    plo,
    output logic [DW-1:0]    phi,
    output logic [DW-1:0]    x_q,
    output logic [DW-1:0]    y_q,
    output logic [2*DW-1:0]  pc_q,
    output logic             store_q,
    output logic             taken_q
);
    localparam int AW = 2 * DW;

    eag_state_e    state_q, state_d;
    logic          launch;
    logic [DW-1:0] zp_ptr;
    logic [DW-1:0] ptr_page;

    assign launch  = (state_q == S_IDLE) && start && !is_fast(mode);
    assign state_o = state_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (launch) state_d = S_OPLO;
            S_OPLO: begin
                if (mode_q inside {AM_ABS, AM_ABX, AM_ABY, AM_IND}) state_d = S_OPHI;
                else if (mode_q inside {AM_IDX, AM_IDY})            state_d = S_PTLO;
                else                                                 state_d = S_FIN;
            end
            S_OPHI: state_d = (mode_q == AM_IND) ? S_PTLO : S_FIN;
            S_PTLO: state_d = S_PTHI;
            S_PTHI: state_d = S_FIN;
            S_FIN:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Captured command and fetched bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= AM_IMP;
            x_q     <= '0;
            y_q     <= '0;
            pc_q    <= '0;
            store_q <= 1'b0;
            taken_q <= 1'b0;
            op0     <= '0;
            op1     <= '0;
            plo     <= '0;
            phi     <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (launch) begin
                    mode_q  <= amode_e'(mode);
                    x_q     <= idx_x;
                    y_q     <= idx_y;
                    pc_q    <= pc_in;
                    store_q <= is_store;
                    taken_q <= br_taken;
                end
                S_OPLO: begin
                    op0  <= rd_data;
                    pc_q <= pc_q + AW'(1);
                end
                S_OPHI: begin
                    op1  <= rd_data;
                    pc_q <= pc_q + AW'(1);
                end
                S_PTLO: plo <= rd_data;
                S_PTHI: phi <= rd_data;
                S_FIN:  ;
                default: ;
            endcase
        end
    end

    // Bus outputs
    always_comb begin
        zp_ptr   = (mode_q == AM_IDX) ? DW'(op0 + x_q) : op0;
        ptr_page = (mode_q == AM_IND) ? op1 : '0;
        rd_en    = 1'b0;
        rd_addr  = '0;
        unique case (state_q)
            S_OPLO, S_OPHI: begin
                rd_en   = 1'b1;
                rd_addr = pc_q;
            end
            S_PTLO: begin
                rd_en   = 1'b1;
                rd_addr = {ptr_page, zp_ptr};
            end
            S_PTHI: begin
                rd_en   = 1'b1;
                rd_addr = {ptr_page, DW'(zp_ptr + DW'(1))};
            end
            default: ;
        endcase
    end

    assert_hi_follows_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OPHI) |-> (rd_addr == $past(rd_addr) + AW'(1)))
        else $error("second operand byte not at next PC");

    assert_ptr_no_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PTHI) |-> ((rd_addr[AW-1:DW] == $past(rd_addr[AW-1:DW])) &&
                                 (rd_addr[DW-1:0] == DW'($past(rd_addr[DW-1:0]) + DW'(1)))))
        else $error("pointer high byte left the page of the low byte");

    assert_zp_pointer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_PTLO || state_q == S_PTHI) && mode_q != AM_IND) |-> (rd_addr[AW-1:DW] == '0))
        else $error("indexed pointer read outside page zero");

    assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> ($stable(mode_q) && $stable(x_q) && $stable(y_q)))
        else $error("command recaptured while busy");

endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
    import eag_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [3:0]       mode,
    input  logic [DW-1:0]    idx_x,
    input  logic [DW-1:0]    idx_y,
    input  logic [2*DW-1:0]  pc_in,
    input  logic             is_store,
    input  logic             br_taken,
    output logic             rd_en,
    output logic [2*DW-1:0]  rd_addr,
    input  logic [DW-1:0]    rd_data,
    output logic             done,
    output logic             busy,
    output logic [2*DW-1:0]  ea,
    output logic [2*DW-1:0]  pc_out,
    output logic [DW-1:0]    rel_off,
    output logic [1:0]       extra
);
    localparam int AW = 2 * DW;

    eag_state_e    state;
    amode_e        mode_q;
    logic [DW-1:0] op0, op1, plo, phi, x_q, y_q;
    logic [AW-1:0] pc_q;
    logic          store_q, taken_q;
    logic [AW-1:0] calc_ea;
    logic [DW-1:0] calc_rel;
    logic [1:0]    calc_extra;
    logic          fast_hit;

    eag_fsm #(.DW(DW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mode    (mode),
        .idx_x   (idx_x),
        .idx_y   (idx_y),
        .pc_in   (pc_in),
        .is_store(is_store),
        .br_taken(br_taken),
        .rd_data (rd_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .state_o (state),
        .mode_q  (mode_q),
        .op0     (op0),
        .op1     (op1),
        .plo     (plo),
        .phi     (phi),
        .x_q     (x_q),
        .y_q     (y_q),
        .pc_q    (pc_q),
        .store_q (store_q),
        .taken_q (taken_q)
    );

    eag_addr_calc #(.DW(DW)) u_calc (
        .mode_q (mode_q),
        .op0    (op0),
        .op1    (op1),
        .plo    (plo),
        .phi    (phi),
        .x_q    (x_q),
        .y_q    (y_q),
        .pc_q   (pc_q),
        .store_q(store_q),
        .taken_q(taken_q),
        .ea     (calc_ea),
        .rel    (calc_rel),
        .extra  (calc_extra)
    );

    // Result outputs: fast path in the start cycle, else from captured state
    always_comb begin
        fast_hit = (state == S_IDLE) && start && is_fast(mode);
        busy     = (state != S_IDLE);
        done     = fast_hit || (state == S_FIN);
        if (fast_hit) begin
            ea      = (mode == 4'(AM_IMM)) ? pc_in : '0;
            pc_out  = (mode == 4'(AM_IMM)) ? pc_in + AW'(1) : pc_in;
            rel_off = '0;
            extra   = 2'd0;
        end else begin
            ea      = calc_ea;
            pc_out  = pc_q;
            rel_off = calc_rel;
            extra   = calc_extra;
        end
    end

    assert_fast_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && is_fast(mode)) |-> (done && !rd_en))
        else $error("fast mode did not finish in its start cycle");

    assert_extra_max_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (extra != 2'd3))
        else $error("extra-cycle count out of range");

    assert_store_penalty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_FIN) && store_q && (mode_q inside {AM_ABX, AM_ABY, AM_IDY})) |-> (extra == 2'd1))
        else $error("indexed store not charged its extra cycle");

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy && !rd_en))
        else $error("block active right after reset");

endmodule

// File: tb/test_eff_addr_gen.sv
`timescale 1ns/1ps
module test_eff_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic [7:0]  idx_x = 8'd0;
    logic [7:0]  idx_y = 8'd0;
    logic [15:0] pc_in = 16'd0;
    logic        is_store = 1'b0;
    logic        br_taken = 1'b0;
    logic        rd_en;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data;
    logic        done;
    logic        busy;
    logic [15:0] ea;
    logic [15:0] pc_out;
    logic [7:0]  rel_off;
    logic [1:0]  extra;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    // Memory contents as a fixed function of the address
    function automatic logic [7:0] hb(input logic [15:0] a);
        return a[7:0] * 8'd37 + a[15:8] * 8'd11 + 8'd60;
    endfunction

    assign rd_data = hb(rd_addr);

    eff_addr_gen #(.DW(8)) i_eff_addr_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .idx_x(idx_x), .idx_y(idx_y), .pc_in(pc_in), .is_store(is_store),
        .br_taken(br_taken), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done), .busy(busy), .ea(ea), .pc_out(pc_out),
        .rel_off(rel_off), .extra(extra)
    );

    function automatic string tag(input logic [3:0] m);
        case (m)
            4'd0, 4'd1:       return "R2";
            4'd2:             return "R3";
            4'd3, 4'd4, 4'd5: return "R4";
            4'd6:             return "R5";
            4'd7, 4'd8:       return "R6";
            4'd9:             return "R9";
            4'd10:            return "R7";
            4'd11:            return "R8";
            4'd12:            return "R10";
            default:          return "R13";
        endcase
    endfunction

    // Reference computed from the requirements
    task automatic model(input logic [3:0] m, input logic [15:0] p,
                         input logic [7:0] xx, input logic [7:0] yy,
                         input logic st, input logic tk,
                         output logic [15:0] e_ea, output logic [15:0] e_pc,
                         output logic [7:0] e_rel, output logic [1:0] e_ex,
                         output int e_lat, output int e_rd);
        logic [7:0]  o, z;
        logic [15:0] b;
        e_ea = 16'd0; e_pc = p; e_rel = 8'd0; e_ex = 2'd0; e_lat = 0; e_rd = 0;
        o = hb(p);
        case (m)
            4'd2: begin e_ea = p; e_pc = p + 16'd1; end
            4'd3, 4'd4, 4'd5: begin
                z = o + ((m == 4'd4) ? xx : (m == 4'd5) ? yy : 8'd0);
                e_ea = {8'h00, z}; e_pc = p + 16'd1; e_lat = 2; e_rd = 1;
            end
            4'd6, 4'd7, 4'd8: begin
                b = {hb(p + 16'd1), o};
                e_pc = p + 16'd2; e_lat = 3; e_rd = 2;
                e_ea = b + {8'h00, (m == 4'd7) ? xx : (m == 4'd8) ? yy : 8'd0};
                if (m != 4'd6) e_ex = (st || (e_ea[15:8] != b[15:8])) ? 2'd1 : 2'd0;
            end
            4'd9: begin
                b = {hb(p + 16'd1), o};
                e_ea = {hb({b[15:8], 8'(b[7:0] + 8'd1)}), hb(b)};
                e_pc = p + 16'd2; e_lat = 5; e_rd = 4;
            end
            4'd10: begin
                z = o + xx;
                e_ea = {hb({8'h00, 8'(z + 8'd1)}), hb({8'h00, z})};
                e_pc = p + 16'd1; e_lat = 4; e_rd = 3;
            end
            4'd11: begin
                b = {hb({8'h00, 8'(o + 8'd1)}), hb({8'h00, o})};
                e_ea = b + {8'h00, yy};
                e_ex = (st || (e_ea[15:8] != b[15:8])) ? 2'd1 : 2'd0;
                e_pc = p + 16'd1; e_lat = 4; e_rd = 3;
            end
            4'd12: begin
                e_pc = p + 16'd1; e_rel = o;
                e_ea = e_pc + {{8{o[7]}}, o};
                e_ex = tk ? ((e_ea[15:8] != e_pc[15:8]) ? 2'd2 : 2'd1) : 2'd0;
                e_lat = 2; e_rd = 1;
            end
            default: ;
        endcase
    endtask

    task automatic run_op(input logic [3:0] m, input logic [15:0] p,
                          input logic [7:0] xx, input logic [7:0] yy,
                          input logic st, input logic tk, input bit poke);
        int lat, nrd, e_lat, e_rd;
        bit got;
        logic [15:0] a_ea, a_pc, e_ea, e_pc;
        logic [7:0]  a_rel, e_rel;
        logic [1:0]  a_ex, e_ex;
        @(negedge clk);
        mode = m; pc_in = p; idx_x = xx; idx_y = yy; is_store = st; br_taken = tk; start = 1'b1;
        lat = 0; nrd = 0; got = 0;
        a_ea = '0; a_pc = '0; a_rel = '0; a_ex = '0;
        for (int c = 0; c < 20; c++) begin
            #1;
            if (rd_en) nrd++;
            if (done) begin
                got = 1; a_ea = ea; a_pc = pc_out; a_rel = rel_off; a_ex = extra;
                break;
            end
            @(negedge clk);
            lat++;
            if (poke) begin
                // R12: conflicting command while busy
                start = 1'b1; mode = 4'd9; pc_in = ~p; idx_x = ~xx; idx_y = ~yy;
                is_store = ~st; br_taken = ~tk;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0;
        model(m, p, xx, yy, st, tk, e_ea, e_pc, e_rel, e_ex, e_lat, e_rd);
        checks++;
        if (!got || a_ea !== e_ea || a_pc !== e_pc || a_rel !== e_rel || a_ex !== e_ex ||
            lat != e_lat || nrd != e_rd) begin
            fails++;
            $display("FAIL %s (R11 timing%s) mode=%0d pc=%h x=%h y=%h st=%0b tk=%0b: ea=%h/%h pc=%h/%h rel=%h/%h extra=%0d/%0d lat=%0d/%0d reads=%0d/%0d (actual/expected)",
                     tag(m), poke ? ", R12 busy poke" : "", m, p, xx, yy, st, tk,
                     a_ea, e_ea, a_pc, e_pc, a_rel, e_rel, a_ex, e_ex, lat, e_lat, nrd, e_rd);
        end
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] wrap_pc;
        // R1: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (done !== 1'b0 || rd_en !== 1'b0 || busy !== 1'b0) begin
            fails++;
            $display("FAIL R1 in reset done=%b rd_en=%b busy=%b expected 0 0 0", done, rd_en, busy);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (done !== 1'b0 || rd_en !== 1'b0 || busy !== 1'b0) begin
            fails++;
            $display("FAIL R1 after reset done=%b rd_en=%b busy=%b expected 0 0 0", done, rd_en, busy);
        end

        // Sweep every mode code over many operand and index patterns
        for (int m = 0; m < 16; m++) begin
            for (int k = 0; k < 80; k++) begin
                run_op(4'(m), 16'(k * 823 + m * 97 + ((k % 4 == 0) ? 16'h00FE : 16'h0000)),
                       8'(k * 29), 8'(k * 53 + 7), k[0], k[1], (k % 5) == 3);
            end
        end

        // R9: indirect pointer whose low byte is 0xFF (no carry into page)
        wrap_pc = 16'h1200;
        for (int i = 0; i < 256; i++) begin
            if (hb(16'h1200 + 16'(i)) == 8'hFF) wrap_pc = 16'h1200 + 16'(i);
        end
        run_op(4'd9, wrap_pc, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        // R7 / R8: zero-page pointer wrap with index pushing to 0xFF
        run_op(4'd10, wrap_pc, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        run_op(4'd11, wrap_pc, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0);
        // R6 store with no crossing, R10 taken and not taken
        run_op(4'd7, 16'h0400, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
        run_op(4'd12, 16'h05FE, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
        run_op(4'd12, 16'h05FE, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule